// File: doc/BRIEF.md
# Dual-Channel PWM Register Controller

This block holds the control and configuration state for two PWM outputs and produces the pad controls for both pins. A host reaches it over a plain 32-bit read/write bus with byte addresses. Reads are combinational from the address. Writes take effect at the next rising clock edge.

Each channel has two generator stages. The first is a 16-bit phase accumulator. It adds the channel's frequency word on every clock cycle and presents its top bit as a variable-frequency square wave. The second stage is an 8-bit on/period counter. It advances once per rising edge of that square wave and gives a constant-frequency PWM waveform. A per-channel select bit chooses which stage reaches the pin. A force-high bit overrides both stages. The pin is then driven either push-pull or open-drain, and an active-low output enable gates it in both modes.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0. Each pad has pad_out = 0 and pad_oe = 1, because the enable bit is active low.
- R2: Word offset 0x00 holds 4 bits per channel, starting at bit 4*n for channel n. Within each field, bit 0 is run, bit 1 is the active-low output enable, bit 2 is force-high and bit 3 is open-drain. Bits 31:8 read 0.
- R3: Word offset 0x04 holds the path select of channel n at bit 4*n. A value of 1 selects the counter stage and 0 selects the accumulator stage. All other bits read 0.
- R4: The channel stride is 8 bytes. The frequency word upper byte is at 0x08+8n, the lower byte at 0x0C+8n, the on count at 0x18+8n and the period count at 0x1C+8n. Each of these stores wdata[7:0] and reads it back in bits 7:0. Any other address, or any address whose bits 1:0 are nonzero, reads 0 and ignores writes.
- R5: While run is 0 for a channel, both of its generator stages are held cleared from the next edge onward, and the counter-stage output is 0.
- R6: While run is 1, the accumulator adds the 16-bit frequency word each cycle. The accumulator stage output is the accumulator's bit 15.
- R7: The counter advances one step per 0-to-1 transition of the accumulator output, one cycle after that transition. After reaching the period value it wraps to 0. The counter-stage output is 1 while run is 1 and count < on count.
- R8: The path select picks the accumulator or counter stage as the channel signal.
- R9: Force-high makes the channel signal 1 regardless of the path select.
- R10: In push-pull mode, pad_out equals the channel signal and pad_oe is the inverse of the output-enable bit.
- R11: In open-drain mode, pad_out is 0 and pad_oe is 1 only while the output-enable bit is 0 and the signal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_out | output | 2 | Pad output value per channel |
| pad_oe | output | 2 | Pad drive enable per channel, active high |

## Verification
The bench builds the block with its default parameters: two channels, a 16-bit frequency word and 8-bit on and period counts. At that size a random period of 0 to 15 and a random frequency word make the counter wrap and its on/period compare change many times within a few thousand cycles. Those same settings also bring in the corner cases: on counts above the period (always high), a period of 0, and a word of 0x8000 that toggles the accumulator output every cycle. Random mixes of force-high, open-drain and the output-enable bit, including mid-run changes to run and the path select, exercise every pad mode against a cycle-accurate model in the bench.

// File: rtl/pwmdc_pkg.sv
`timescale 1ns/1ps
package pwmdc_pkg;
    localparam int NUM_CH     = 2;
    localparam int FIELD_W    = 4;
    localparam int FWORD_W    = 16;
    localparam int BYTE_W     = 8;
    localparam int CNT_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int WIDX_W     = ADDR_W - 2;

    // Channel control field; bit order matches the bus layout.
    typedef struct packed {
        logic drain;
        logic force_hi;
        logic oe_n;
        logic run;
    } ch_ctrl_t;

    typedef struct packed {
        logic [FWORD_W-1:0] fword;
        logic [CNT_W-1:0]   on_cnt;
        logic [CNT_W-1:0]   per_cnt;
    } ch_cfg_t;

    typedef enum logic [2:0] {
        K_NONE, K_CTRL, K_SEL, K_FW_HI, K_FW_LO, K_ON, K_PER
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t kind;
        logic      ch;
    } reg_hit_t;

    // Word-index decode; the channel bit follows from the 8-byte stride.
    function automatic reg_hit_t decode_addr(logic [ADDR_W-1:0] a);
        reg_hit_t h;
        logic [WIDX_W-1:0] w;
        w      = a[ADDR_W-1:2];
        h.kind = K_NONE;
        h.ch   = ~w[1];
        if (a[1:0] == 2'b00) begin
            case (w)
                6'd0: h.kind = K_CTRL;
                6'd1: h.kind = K_SEL;
                6'd2, 6'd4: h.kind = K_FW_HI;
                6'd3, 6'd5: h.kind = K_FW_LO;
                6'd6, 6'd8: h.kind = K_ON;
                6'd7, 6'd9: h.kind = K_PER;
                default: h.kind = K_NONE;
            endcase
        end
        return h;
    endfunction

    function automatic logic pick_signal(ch_ctrl_t c, logic sel, logic var_s, logic pwm_s);
        if (c.force_hi) return 1'b1;
        return sel ? pwm_s : var_s;
    endfunction
endpackage

// File: rtl/pwmdc_regfile.sv
`timescale 1ns/1ps
module pwmdc_regfile
    import pwmdc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output ch_ctrl_t [NUM_CH-1:0]             ctrl_o,
    output logic [NUM_CH-1:0]                 sel_o,
    output ch_cfg_t [NUM_CH-1:0]              cfg_o
);
    ch_ctrl_t [NUM_CH-1:0] ctrl_q;
    logic [NUM_CH-1:0]     sel_q;
    ch_cfg_t [NUM_CH-1:0]  cfg_q;
    reg_hit_t              hit;

    assign hit = decode_addr(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
            cfg_q  <= '0;
        end else if (we) begin
            case (hit.kind)
                K_CTRL: begin
                    for (int n = 0; n < NUM_CH; n++)
                        ctrl_q[n] <= ch_ctrl_t'(wdata[FIELD_W*n +: FIELD_W]);
                end
                K_SEL: begin
                    for (int n = 0; n < NUM_CH; n++)
                        sel_q[n] <= wdata[FIELD_W*n];
                end
                K_FW_HI: cfg_q[hit.ch].fword[FWORD_W-1 -: BYTE_W] <= wdata[BYTE_W-1:0];
                K_FW_LO: cfg_q[hit.ch].fword[BYTE_W-1:0]          <= wdata[BYTE_W-1:0];
                K_ON:    cfg_q[hit.ch].on_cnt                     <= wdata[CNT_W-1:0];
                K_PER:   cfg_q[hit.ch].per_cnt                    <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (hit.kind)
            K_CTRL: begin
                for (int n = 0; n < NUM_CH; n++)
                    rdata[FIELD_W*n +: FIELD_W] = ctrl_q[n];
            end
            K_SEL: begin
                for (int n = 0; n < NUM_CH; n++)
                    rdata[FIELD_W*n] = sel_q[n];
            end
            K_FW_HI: rdata[BYTE_W-1:0] = cfg_q[hit.ch].fword[FWORD_W-1 -: BYTE_W];
            K_FW_LO: rdata[BYTE_W-1:0] = cfg_q[hit.ch].fword[BYTE_W-1:0];
            K_ON:    rdata[CNT_W-1:0]  = cfg_q[hit.ch].on_cnt;
            K_PER:   rdata[CNT_W-1:0]  = cfg_q[hit.ch].per_cnt;
            default: rdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign sel_o  = sel_q;
    assign cfg_o  = cfg_q;
endmodule

// File: rtl/pwmdc_var_gen.sv
`timescale 1ns/1ps
module pwmdc_var_gen #(
    parameter int NCH = 2,
    parameter int FW  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         run,
    input  logic [NCH-1:0][FW-1:0] fword,
    output logic [NCH-1:0]         var_o,
    output logic [NCH-1:0]         tick_o
);
    localparam int MSB = FW - 1;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [FW-1:0] acc_q;
        logic [FW-1:0] acc_nxt;
        logic          tick_q;

        assign acc_nxt = acc_q + fword[g];

        always_ff @(posedge clk) begin
            if (rst || !run[g]) begin
                acc_q  <= '0;
                tick_q <= 1'b0;
            end else begin
                acc_q  <= acc_nxt;
                tick_q <= ~acc_q[MSB] & acc_nxt[MSB];
            end
        end

        assign var_o[g]  = acc_q[MSB];
        assign tick_o[g] = tick_q;
    end
endmodule

// File: rtl/pwmdc_const_gen.sv
`timescale 1ns/1ps
module pwmdc_const_gen #(
    parameter int NCH = 2,
    parameter int CW  = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         run,
    input  logic [NCH-1:0]         tick,
    input  logic [NCH-1:0][CW-1:0] on_cnt,
    input  logic [NCH-1:0][CW-1:0] per_cnt,
    output logic [NCH-1:0]         pwm_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst || !run[g]) begin
                cnt_q <= '0;
            end else if (tick[g]) begin
                cnt_q <= (cnt_q >= per_cnt[g]) ? '0 : cnt_q + 1'b1;
            end
        end

        assign pwm_o[g] = run[g] & (cnt_q < on_cnt[g]);
    end
endmodule

// File: rtl/pwmdc_pad_ctl.sv
`timescale 1ns/1ps
module pwmdc_pad_ctl
    import pwmdc_pkg::*;
(
    input  ch_ctrl_t [NUM_CH-1:0] ctrl,
    input  logic [NUM_CH-1:0]     sel,
    input  logic [NUM_CH-1:0]     var_s,
    input  logic [NUM_CH-1:0]     pwm_s,
    output logic [NUM_CH-1:0]     pad_out,
    output logic [NUM_CH-1:0]     pad_oe
);
    for (genvar g = 0; g < NCH_LOCAL; g++) begin : g_ch
        logic sig;
        assign sig        = pick_signal(ctrl[g], sel[g], var_s[g], pwm_s[g]);
        assign pad_out[g] = ctrl[g].drain ? 1'b0 : sig;
        assign pad_oe[g]  = ~ctrl[g].oe_n & (ctrl[g].drain ? ~sig : 1'b1);
    end
    localparam int NCH_LOCAL = NUM_CH;
endmodule

// File: rtl/pwm_dual_ctrl.sv
`timescale 1ns/1ps
module pwm_dual_ctrl
    import pwmdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pad_out,
    output logic [NUM_CH-1:0] pad_oe
);
    ch_ctrl_t [NUM_CH-1:0]             ctrl_w;
    logic [NUM_CH-1:0]                 sel_w;
    ch_cfg_t [NUM_CH-1:0]              cfg_w;
    logic [NUM_CH-1:0]                 run_w;
    logic [NUM_CH-1:0][FWORD_W-1:0]    fword_w;
    logic [NUM_CH-1:0][CNT_W-1:0]      on_w;
    logic [NUM_CH-1:0][CNT_W-1:0]      per_w;
    logic [NUM_CH-1:0]                 var_w;
    logic [NUM_CH-1:0]                 tick_w;
    logic [NUM_CH-1:0]                 pwm_w;

    pwmdc_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_o (ctrl_w),
        .sel_o  (sel_w),
        .cfg_o  (cfg_w)
    );

    always_comb begin
        for (int n = 0; n < NUM_CH; n++) begin
            run_w[n]   = ctrl_w[n].run;
            fword_w[n] = cfg_w[n].fword;
            on_w[n]    = cfg_w[n].on_cnt;
            per_w[n]   = cfg_w[n].per_cnt;
        end
    end

    pwmdc_var_gen #(.NCH(NUM_CH), .FW(FWORD_W)) u_var (
        .clk    (clk),
        .rst    (rst),
        .run    (run_w),
        .fword  (fword_w),
        .var_o  (var_w),
        .tick_o (tick_w)
    );

    pwmdc_const_gen #(.NCH(NUM_CH), .CW(CNT_W)) u_const (
        .clk     (clk),
        .rst     (rst),
        .run     (run_w),
        .tick    (tick_w),
        .on_cnt  (on_w),
        .per_cnt (per_w),
        .pwm_o   (pwm_w)
    );

    pwmdc_pad_ctl u_pad (
        .ctrl    (ctrl_w),
        .sel     (sel_w),
        .var_s   (var_w),
        .pwm_s   (pwm_w),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/pwm_dual_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_dual_ctrl_chk
    import pwmdc_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input ch_ctrl_t [NUM_CH-1:0] ctrl,
    input logic [NUM_CH-1:0]     var_s,
    input logic [NUM_CH-1:0]     tick_s,
    input logic [NUM_CH-1:0]     pwm_s,
    input logic [NUM_CH-1:0]     pad_out,
    input logic [NUM_CH-1:0]     pad_oe
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            (!ctrl[g].run && $past(!ctrl[g].run)) |-> (!var_s[g] && !pwm_s[g]));

        p_tick_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
            tick_s[g] |-> (var_s[g] && !$past(var_s[g])));

        p_force_drives_r9: assert property (@(posedge clk) disable iff (rst)
            (ctrl[g].force_hi && !ctrl[g].drain) |-> pad_out[g]);

        p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
            ctrl[g].oe_n |-> !pad_oe[g]);

        p_drain_low_r11: assert property (@(posedge clk) disable iff (rst)
            ctrl[g].drain |-> !pad_out[g]);

        p_drain_float_r11: assert property (@(posedge clk) disable iff (rst)
            (ctrl[g].drain && ctrl[g].force_hi) |-> !pad_oe[g]);
    end
endmodule

bind pwm_dual_ctrl pwm_dual_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl_w),
    .var_s   (var_w),
    .tick_s  (tick_w),
    .pwm_s   (pwm_w),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/pwm_dual_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_dual_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;
    localparam int RAND_CYC   = 6000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pad_out;
    logic [1:0]  pad_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    pwm_dual_ctrl u_pwm_dual_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Shadow of the programmed state and model of the generators.
    logic [3:0]  s_ctrl [2];
    logic        s_sel  [2];
    logic [15:0] s_fw   [2];
    logic [7:0]  s_on   [2];
    logic [7:0]  s_per  [2];
    logic [15:0] m_acc  [2];
    logic        m_tick [2];
    logic [7:0]  m_cnt  [2];

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            s_ctrl[c] = '0; s_sel[c] = 1'b0; s_fw[c] = '0;
            s_on[c] = '0; s_per[c] = '0;
            m_acc[c] = '0; m_tick[c] = 1'b0; m_cnt[c] = '0;
        end
    endtask

    task automatic model_edge();
        for (int c = 0; c < 2; c++) begin
            if (!s_ctrl[c][0]) begin
                m_acc[c] = '0; m_tick[c] = 1'b0; m_cnt[c] = '0;
            end else begin
                logic [15:0] nxt;
                if (m_tick[c]) m_cnt[c] = (m_cnt[c] >= s_per[c]) ? 8'd0 : m_cnt[c] + 8'd1;
                nxt = m_acc[c] + s_fw[c];
                m_tick[c] = !m_acc[c][15] && nxt[15];
                m_acc[c] = nxt;
            end
        end
    endtask

    task automatic shadow_write(logic [7:0] a, logic [31:0] d);
        int w;
        int c;
        if (a[1:0] != 2'b00) return;
        w = int'(a[7:2]);
        c = (w == 2 || w == 3 || w == 6 || w == 7) ? 0 : 1;
        case (w)
            0: begin s_ctrl[0] = d[3:0]; s_ctrl[1] = d[7:4]; end
            1: begin s_sel[0] = d[0]; s_sel[1] = d[4]; end
            2, 4: s_fw[c][15:8] = d[7:0];
            3, 5: s_fw[c][7:0]  = d[7:0];
            6, 8: s_on[c]  = d[7:0];
            7, 9: s_per[c] = d[7:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int w;
        int c;
        if (a[1:0] != 2'b00) return 32'd0;
        w = int'(a[7:2]);
        c = (w == 2 || w == 3 || w == 6 || w == 7) ? 0 : 1;
        case (w)
            0: return {24'd0, s_ctrl[1], s_ctrl[0]};
            1: return {27'd0, s_sel[1], 3'd0, s_sel[0]};
            2, 4: return {24'd0, s_fw[c][15:8]};
            3, 5: return {24'd0, s_fw[c][7:0]};
            6, 8: return {24'd0, s_on[c]};
            7, 9: return {24'd0, s_per[c]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_pads();
        for (int c = 0; c < 2; c++) begin
            logic run, oen, frc, od, pwm, vr, sig, eo, eoe;
            string lbl;
            run = s_ctrl[c][0]; oen = s_ctrl[c][1]; frc = s_ctrl[c][2]; od = s_ctrl[c][3];
            pwm = run && (m_cnt[c] < s_on[c]);
            vr  = m_acc[c][15];
            sig = frc ? 1'b1 : (s_sel[c] ? pwm : vr);
            eo  = od ? 1'b0 : sig;
            eoe = !oen && (od ? !sig : 1'b1);
            if (frc)           lbl = "R9 pad_out";
            else if (od)       lbl = "R11 pad_out";
            else if (!s_sel[c]) lbl = "R6 R8 pad_out";
            else if (run)      lbl = "R7 R8 pad_out";
            else               lbl = "R5 R8 pad_out";
            check(lbl, {31'd0, pad_out[c]}, {31'd0, eo});
            check(od ? "R11 pad_oe" : "R10 pad_oe", {31'd0, pad_oe[c]}, {31'd0, eoe});
        end
    endtask

    task automatic step(logic we, logic [7:0] a, logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        model_edge();
        if (we) shadow_write(a, d);
        bus_we = 1'b0;
        check_pads();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'd0);
    endtask

    task automatic rd(string req, logic [7:0] a);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        rst = 1'b0;
    endtask

    function automatic logic [3:0] rand_ctrl();
        logic [3:0] v;
        v[0] = ($urandom % 10) < 8;
        v[1] = ($urandom % 10) < 2;
        v[2] = ($urandom % 20) < 3;
        v[3] = ($urandom % 10) < 3;
        return v;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(SEED));
        model_reset();
        do_reset();

        // R1: reset state of registers and pads
        for (int a = 0; a < 64; a += 4) rd("R1 reset readback", 8'(a));
        check("R1 reset pad_out", {30'd0, pad_out}, 32'd0);
        check("R1 reset pad_oe",  {30'd0, pad_oe},  32'd3);

        // R2: all-ones write to the control word keeps only the channel fields
        step(1'b1, 8'h00, 32'hFFFF_FFFF);
        check("R2 ctrl unused bits", bus_rdata, 32'h0000_00FF);
        rd("R2 ctrl readback", 8'h00);
        step(1'b1, 8'h00, 32'h0000_00A5);
        rd("R2 ctrl field layout", 8'h00);

        // R3: path select bits only at 4*n
        step(1'b1, 8'h04, 32'hFFFF_FFFF);
        bus_addr = 8'h04; #1;
        check("R3 select unused bits", bus_rdata, 32'h0000_0011);

        // R4: per-channel offsets, byte-wide storage, unmapped addresses
        step(1'b1, 8'h08, 32'hABCD_1201);
        step(1'b1, 8'h0C, 32'h0000_3402);
        step(1'b1, 8'h10, 32'h0000_5603);
        step(1'b1, 8'h14, 32'h0000_7804);
        step(1'b1, 8'h18, 32'h0000_0905);
        step(1'b1, 8'h1C, 32'h0000_0A06);
        step(1'b1, 8'h20, 32'h0000_0B07);
        step(1'b1, 8'h24, 32'h0000_0C08);
        bus_addr = 8'h10; #1;
        check("R4 ch1 freq upper byte", bus_rdata, 32'h0000_0003);
        for (int a = 8; a < 40; a += 4) rd("R4 channel registers", 8'(a));
        step(1'b1, 8'h28, 32'hFFFF_FFFF);
        step(1'b1, 8'h19, 32'hFFFF_FFFF);
        rd("R4 unmapped read", 8'h28);
        rd("R4 misaligned read", 8'h19);
        bus_addr = 8'h18; #1;
        check("R4 misaligned write ignored", bus_rdata, 32'h0000_0005);
        for (int a = 0; a < 64; a += 4) rd("R4 state after ignored writes", 8'(a));

        // R6: word 0x8000 toggles the accumulator output every cycle
        step(1'b1, 8'h04, 32'h0);
        step(1'b1, 8'h08, 32'h80);
        step(1'b1, 8'h0C, 32'h00);
        step(1'b1, 8'h00, 32'h0000_0001);
        idle(8);

        // R7: counter path with on=2, period=3, then on above period, then period 0
        step(1'b1, 8'h18, 32'd2);
        step(1'b1, 8'h1C, 32'd3);
        step(1'b1, 8'h04, 32'h1);
        idle(40);
        step(1'b1, 8'h18, 32'd9);
        idle(20);
        step(1'b1, 8'h1C, 32'd0);
        step(1'b1, 8'h18, 32'd1);
        idle(20);

        // R5: clearing run stops both stages
        step(1'b1, 8'h00, 32'h0);
        idle(6);
        step(1'b1, 8'h04, 32'h0);
        idle(4);

        // Random phase covering every mode combination
        for (int i = 0; i < RAND_CYC; i++) begin
            int pick;
            int c;
            pick = int'($urandom % 40);
            c = int'($urandom % 2);
            case (pick)
                0: step(1'b1, 8'h00, {24'd0, rand_ctrl(), rand_ctrl()});
                1: step(1'b1, 8'h04, $urandom);
                2: step(1'b1, 8'(8'h08 + 8*c), $urandom);
                3: step(1'b1, 8'(8'h0C + 8*c), $urandom);
                4: step(1'b1, 8'(8'h18 + 8*c), $urandom % 18);
                5: step(1'b1, 8'(8'h1C + 8*c), $urandom % 16);
                6: step(1'b1, 8'($urandom), $urandom);
                7: begin
                    step(1'b0, 8'h00, 32'd0);
                    rd("R2 R3 R4 random readback", 8'(($urandom % 16) * 4));
                end
                default: step(1'b0, 8'h00, 32'd0);
            endcase
        end

        // R1: reset in mid-run clears everything again
        do_reset();
        for (int a = 0; a < 64; a += 4) rd("R1 second reset readback", 8'(a));
        check("R1 second reset pad_oe", {30'd0, pad_oe}, 32'd3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule